// File: doc/BRIEF.md
# Dual Programmable Serial Rate Divider

This block turns a single 4.9152 MHz reference clock into two independent timing streams, one per serial channel, each running at sixteen times a selectable line rate. Software picks a rate by writing a byte to the channel's own write port. Channel 0 uses only the low four bits of the byte and channel 1 uses only the high four bits, so a byte with the same code in both halves selects the same rate on whichever port it is written to.

Each four-bit code selects one of sixteen standard line rates between 50 and 19200 baud, including the odd 134.5 rate. The block turns the code into an integer divisor of the reference clock. Each channel has two outputs: a one-cycle enable pulse at the 16x rate, and a clock of close to 50% duty at the same rate. A hard reset loads fixed default rates. A warm reset only restarts the dividers and keeps whatever rates were programmed. A rate change never cuts the period that is in progress short.

Top module: `baud_pair_gen`

## Requirements
- R1: The enable pulse period, in reference cycles, equals the divisor of the active code. The divisors for codes 0x0 to 0xF are 6144, 4096, 2793, 2284, 2048, 1024, 512, 256, 171, 154, 128, 85, 64, 43, 32 and 16. These come from 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 baud, each divided into 4915200/16 and rounded.
- R2: A write on `wr_en[0]` loads the channel 0 code from `wdata[3:0]`. A write on `wr_en[1]` loads the channel 1 code from `wdata[7:4]`. The other nibble of each byte is ignored.
- R3: A write to one channel's port leaves the other channel's period unchanged.
- R4: While `rst` is high, every `tick` and `sqclk` output is 0. After `rst` is released, channel 0 runs at code 0x5 (period 1024) and channel 1 at code 0xE (period 32).
- R5: `warm_rst` keeps both programmed codes. It holds the outputs low while it is high, and both `tick` bits rise in the first cycle after it is released.
- R6: A code written mid-period takes effect at the next terminal count. The period in progress completes with the old divisor, and the next period uses the new one.
- R7: Each `tick` pulse is high for exactly one reference cycle.
- R8: `sqclk` rises in the same cycle as `tick`. In each period of length D it stays high for D - floor(D/2) cycles and is low for the rest.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.9152 MHz reference clock |
| rst | input | 1 | Synchronous active-high hard reset; loads the default codes |
| warm_rst | input | 1 | Synchronous active-high restart of the dividers; codes are kept |
| wr_en | input | 2 | Per-channel write strobe (bit 0 for channel 0, bit 1 for channel 1) |
| wdata | input | 8 | Write byte; channel 0 uses [3:0], channel 1 uses [7:4] |
| tick | output | 2 | One-cycle 16x enable pulse per channel |
| sqclk | output | 2 | Roughly 50% duty 16x clock per channel |

## Verification
The assertions assume that `rst` and `warm_rst` are never raised together with a write. They also assume that every code gives a divisor of at least 16, so two pulses on one channel are always at least 15 idle cycles apart unless a reset intervenes. The stimulus respects both: each write, each warm reset and each hard reset is applied in a separate window, and only codes from the sixteen-entry table are written. Periods are measured from one pulse to the next, so the checks do not depend on where in a period a write happens to land.

// File: rtl/baud_pair_pkg.sv
package baud_pair_pkg;

    localparam int NUM_CH     = 2;
    localparam int CODE_W     = 4;
    localparam int DIV_W      = 13;
    localparam int REF_HZ     = 4915200;
    localparam int OVERSAMPLE = 16;
    localparam int MIN_DIV    = 16;

    typedef logic [CODE_W-1:0] rate_code_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        div_t cnt;
        div_t half;
        logic tick;
    } div_state_t;

    // line rate in tenths of a baud, so 134.5 stays exact
    function automatic int rate_x10(rate_code_t c);
        case (c)
            4'h0:    return 500;
            4'h1:    return 750;
            4'h2:    return 1100;
            4'h3:    return 1345;
            4'h4:    return 1500;
            4'h5:    return 3000;
            4'h6:    return 6000;
            4'h7:    return 12000;
            4'h8:    return 18000;
            4'h9:    return 20000;
            4'hA:    return 24000;
            4'hB:    return 36000;
            4'hC:    return 48000;
            4'hD:    return 72000;
            4'hE:    return 96000;
            default: return 192000;
        endcase
    endfunction

    // rounded reference cycles per 16x period
    function automatic div_t code_to_div(rate_code_t c);
        int num;
        int den;
        num = REF_HZ * 10;
        den = OVERSAMPLE * rate_x10(c);
        return div_t'((num + den / 2) / den);
    endfunction

    function automatic rate_code_t default_code(int ch);
        return (ch == 0) ? rate_code_t'(4'h5) : rate_code_t'(4'hE);
    endfunction

endpackage

// File: rtl/baud_code_reg.sv
module baud_code_reg
    import baud_pair_pkg::*;
#(
    parameter int LANE = 0,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output rate_code_t        code_o
);
    localparam int LSB = LANE * CODE_W;
    localparam rate_code_t RST_CODE = default_code(LANE);

    rate_code_t code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= RST_CODE;
        else if (wr)
            code_q <= wdata[LSB +: CODE_W];
    end

    assign code_o = code_q;
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       warm_rst,
    input  rate_code_t code_i,
    output logic       tick_o,
    output logic       sqclk_o
);
    div_state_t st_q;
    div_t       div_sel;

    assign div_sel = code_to_div(code_i);

    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            st_q <= '0;
        end else if (st_q.cnt == '0) begin
            st_q.cnt  <= div_sel - div_t'(1);
            st_q.half <= div_sel >> 1;
            st_q.tick <= 1'b1;
        end else begin
            st_q.cnt  <= st_q.cnt - div_t'(1);
            st_q.tick <= 1'b0;
        end
    end

    assign tick_o  = st_q.tick;
    assign sqclk_o = (st_q.half != '0) && (st_q.cnt >= st_q.half);
endmodule

// File: rtl/baud_pair_gen.sv
module baud_pair_gen
    import baud_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic [NUM_CH-1:0] wr_en,
    input  logic [7:0]        wdata,
    output logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-1:0] sqclk
);
    logic [NUM_CH*CODE_W-1:0] code_vec;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        rate_code_t code_w;

        baud_code_reg #(.LANE(ch), .BYTE_W(8)) u_code (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_en[ch]),
            .wdata (wdata),
            .code_o(code_w)
        );

        baud_divider u_div (
            .clk     (clk),
            .rst     (rst),
            .warm_rst(warm_rst),
            .code_i  (code_w),
            .tick_o  (tick[ch]),
            .sqclk_o (sqclk[ch])
        );

        assign code_vec[ch*CODE_W +: CODE_W] = code_w;
    end
endmodule

// File: rtl/baud_pair_chk.sv
module baud_pair_chk
    import baud_pair_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     warm_rst,
    input logic [NUM_CH-1:0]        wr_en,
    input logic [7:0]               wdata,
    input logic [NUM_CH-1:0]        tick,
    input logic [NUM_CH-1:0]        sqclk,
    input logic [NUM_CH*CODE_W-1:0] code_vec
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        logic [DIV_W:0] gap_q;
        logic           seen_q;

        always_ff @(posedge clk) begin
            if (rst || warm_rst) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
            end else if (tick[ch]) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end

        AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst || warm_rst) (tick[ch] && seen_q) |-> (gap_q >= (MIN_DIV - 1))); // R1
        AST_LANE_LOAD: assert property (@(posedge clk) disable iff (rst) wr_en[ch] |=> (code_vec[ch*CODE_W +: CODE_W] == $past(wdata[ch*CODE_W +: CODE_W]))); // R2
        AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_en[ch] |=> $stable(code_vec[ch*CODE_W +: CODE_W])); // R5
        AST_DEFAULT_LOAD: assert property (@(posedge clk) rst |=> (code_vec[ch*CODE_W +: CODE_W] == default_code(ch))); // R4
        AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst || warm_rst) tick[ch] |=> !tick[ch]); // R7
        AST_CLK_AT_TICK: assert property (@(posedge clk) disable iff (rst || warm_rst) tick[ch] |-> sqclk[ch]); // R8
    end
endmodule

bind baud_pair_gen baud_pair_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .warm_rst(warm_rst),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .tick    (tick),
    .sqclk   (sqclk),
    .code_vec(code_vec)
);

// File: tb/baud_pair_gen_test.sv
module baud_pair_gen_test;
    logic       clk;
    logic       rst;
    logic       warm_rst;
    logic [1:0] wr_en;
    logic [7:0] wdata;
    logic [1:0] tick;
    logic [1:0] sqclk;

    int checks;
    int fails;
    int cyc;

    localparam int WATCHDOG = 190000;

    baud_pair_gen uut (
        .clk     (clk),
        .rst     (rst),
        .warm_rst(warm_rst),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .tick    (tick),
        .sqclk   (sqclk)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic int exp_div(int code);
        case (code)
            0: return 6144;   1: return 4096;  2: return 2793;  3: return 2284;
            4: return 2048;   5: return 1024;  6: return 512;   7: return 256;
            8: return 171;    9: return 154;   10: return 128;  11: return 85;
            12: return 64;    13: return 43;   14: return 32;   default: return 16;
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected <= %0d)", WATCHDOG, cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_port(input int p, input logic [7:0] d);
        @(negedge clk);
        wr_en[p] = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wait_tick(input int ch);
        do @(negedge clk); while (!tick[ch]);
    endtask

    task automatic count_to_tick(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[ch]);
    endtask

    // from one pulse to the next: period, high cycles, width of the pulse
    task automatic measure(input int ch, output int per, output int hi);
        bit wide;
        wait_tick(ch);
        per = 0;
        hi = 0;
        wide = 1'b0;
        do begin
            if (sqclk[ch]) hi++;
            per++;
            @(negedge clk);
            if (per == 1 && tick[ch]) wide = 1'b1;
        end while (!tick[ch] || per == 1);
        chk(!wide, "R7 pulse width", wide ? 2 : 1, 1);
    endtask

    task automatic t_reset();
        int per, hi;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(tick == 2'b00, "R4 tick in reset", tick, 0);
        chk(sqclk == 2'b00, "R4 sqclk in reset", sqclk, 0);
        rst = 1'b0;
        measure(0, per, hi);
        chk(per == 1024, "R4 ch0 default period", per, 1024);
        measure(1, per, hi);
        chk(per == 32, "R4 ch1 default period", per, 32);
        chk(hi == 16, "R8 ch1 default high", hi, 16);
    endtask

    task automatic t_table();
        int per, hi;
        for (int c = 0; c < 16; c++) begin
            write_port(0, {~4'(c), 4'(c)});
            wait_tick(0);
            measure(0, per, hi);
            chk(per == exp_div(c), "R1 ch0 period", per, exp_div(c));
            chk(hi == per - per / 2, "R8 ch0 high", hi, per - per / 2);
        end
        measure(1, per, hi);
        chk(per == 32, "R3 ch1 untouched by port 0", per, 32);
    endtask

    task automatic t_lane();
        int per, hi;
        write_port(1, 8'h3C);
        wait_tick(1);
        measure(1, per, hi);
        chk(per == 2284, "R2 ch1 uses high nibble", per, 2284);
        measure(0, per, hi);
        chk(per == 16, "R3 ch0 untouched by port 1", per, 16);
        write_port(0, 8'h77);
        write_port(1, 8'h77);
        wait_tick(0);
        measure(0, per, hi);
        chk(per == 256, "R2 ch0 doubled code", per, 256);
        wait_tick(1);
        measure(1, per, hi);
        chk(per == 256, "R2 ch1 doubled code", per, 256);
    endtask

    task automatic t_switch();
        int n, per;
        wait_tick(1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 100) begin
                wr_en[1] = 1'b1;
                wdata = 8'hF3;
            end else begin
                wr_en = '0;
            end
        end while (!tick[1]);
        wr_en = '0;
        chk(n == 256, "R6 running period kept", n, 256);
        count_to_tick(1, per);
        chk(per == 16, "R6 new period after terminal count", per, 16);
        count_to_tick(1, per);
        chk(per == 16, "R6 new period holds", per, 16);
    endtask

    task automatic t_warm();
        int per, hi;
        @(negedge clk);
        warm_rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(tick == 2'b00, "R5 tick held in warm reset", tick, 0);
        warm_rst = 1'b0;
        @(negedge clk);
        chk(tick == 2'b11, "R5 restart pulse", tick, 3);
        count_to_tick(0, per);
        chk(per == 256, "R5 ch0 code kept", per, 256);
        measure(1, per, hi);
        chk(per == 16, "R5 ch1 code kept", per, 16);
    endtask

    task automatic t_hard();
        int per, hi;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(tick == 2'b00, "R4 tick in hard reset", tick, 0);
        rst = 1'b0;
        measure(0, per, hi);
        chk(per == 1024, "R4 ch0 reloads default", per, 1024);
        chk(hi == 512, "R8 ch0 default high", hi, 512);
        measure(1, per, hi);
        chk(per == 32, "R4 ch1 reloads default", per, 32);
    endtask

    initial begin
        checks = 0;
        fails = 0;
        cyc = 0;
        rst = 1'b1;
        warm_rst = 1'b0;
        wr_en = '0;
        wdata = '0;
        t_reset();
        t_table();
        t_lane();
        t_switch();
        t_warm();
        t_hard();
        summary();
        $finish;
    end
endmodule